// File: doc/BRIEF.md
# Flash Write Protection Gate

This block stands between a flash program/erase controller and the flash array and decides, for every write, page-erase or chip-erase request, whether the operation may proceed. It keeps a copy of the lock byte held in the first word (offset 0x000) of the flash information page. The controller loads that byte through a load strobe, and the block answers each request with a one-cycle grant or deny pulse on the cycle after the request.

Three protections are applied. The first is a write-protected window that begins at the top of a 128 KB array and reaches downward by one of eight sizes. The second is an active-low lock on the boot page (addresses 0x0000 to 0x07FF). The third is an active-low debug-disable flag, which the block exports so the debug port can gate its commands. The information page itself can be reached only by requests that arrive over the debug link. A chip erase is always allowed, and when it completes the stored lock byte becomes 8'hFF, which removes every protection.

Top module: `flash_guard`

## Requirements
- R1: While reset is applied and afterwards until the first load, the stored lock byte is 8'h00. In that state dbg_locked is 1 and grant and deny are both 0.
- R2: A request sampled with req_valid high gives exactly one of grant or deny, high for one cycle, on the next clock edge. Without a request both outputs are 0.
- R3: The lock byte is taken from cfg_byte on a cycle with cfg_load high. Bit 0 is the debug lock, and dbg_locked equals the inverse of that bit.
- R4: Bits 3:1 of the lock byte hold a size field s. The protected size is 0 KB for s=7 and 128 KB >> s for s=0..6, so s=6 gives 2 KB and s=0 gives 128 KB. A write or page erase with address >= 0x20000 minus that size is denied.
- R5: When bit 4 of the lock byte is 0, a write or page erase to an address below 0x00800 is denied.
- R6: A write or page erase with req_info high targets the information page. It is denied when req_from_dbg is 0 and granted when req_from_dbg is 1, whatever the lock byte holds. The address is ignored in this case.
- R7: A chip-erase request is always granted.
- R8: An erase_done pulse sets the stored lock byte to 8'hFF on the following edge. It takes priority over a load in the same cycle.
- R9: req_kind is encoded as 0 for write, 1 for page erase, 2 for chip erase and 3 for reserved. A reserved request is denied.
- R10: A request on the same cycle as cfg_load is judged against the lock byte held before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load strobe for the lock byte |
| cfg_byte | input | 8 | Lock byte read from the information page |
| erase_done | input | 1 | Chip erase finished; lock byte becomes 8'hFF |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 write, 1 page erase, 2 chip erase, 3 reserved |
| req_addr | input | 17 | Byte address in the main array |
| req_info | input | 1 | Request targets the information page |
| req_from_dbg | input | 1 | Request arrives over the debug link |
| grant | output | 1 | One-cycle pulse: operation allowed |
| deny | output | 1 | One-cycle pulse: operation refused |
| dbg_locked | output | 1 | Debug support disabled |

## Verification
The hardest cases to reach from the ports are the ones where the lock byte changes at the same moment a request is judged. One is a load that coincides with a request. The other is the return to an open state after a chip erase when the device was fully locked. To reach them, the stimulus first loads a byte that protects the whole array and then issues a request on the same cycle as a load that would unlock it, which must still be denied. A separate sequence locks everything, requests a chip erase, pulses erase_done, and confirms that the debug flag is released and that a top-of-memory write is then granted. The table of vectors sweeps the window edges at the first protected address and one below it for several sizes.

// File: rtl/flash_guard_pkg.sv
// Package: shared request encoding and lock byte layout for flash_guard.
// Assumes the lock byte fits in 8 bits with 3 spare upper bits.
package flash_guard_pkg;

    typedef enum logic [1:0] {
        KIND_WRITE  = 2'd0,
        KIND_PERASE = 2'd1,
        KIND_CERASE = 2'd2,
        KIND_RSVD   = 2'd3
    } req_kind_e;

    typedef struct packed {
        logic [2:0] spare;
        logic       boot_open;  // 0 = boot page protected
        logic [2:0] size_sel;   // 7 = nothing protected
        logic       dbg_open;   // 0 = debug disabled
    } lock_t;

endpackage

// File: rtl/lock_store.sv
// lock_store: holds the lock byte. A wipe (end of chip erase) forces it to
// all ones and overrides a load; reset leaves it fully locked.
// Assumes wipe and load are single-cycle strobes from the controller.
module lock_store
    import flash_guard_pkg::*;
#(
    parameter logic [7:0] RESET_VAL = 8'h00,
    parameter logic [7:0] WIPE_VAL  = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       wipe,
    output lock_t      lock_q
);

    // Keep the current lock byte; wipe has priority over load.
    always_ff @(posedge clk) begin
        if (!rst_n)      lock_q <= lock_t'(RESET_VAL);
        else if (wipe)   lock_q <= lock_t'(WIPE_VAL);
        else if (load)   lock_q <= lock_t'(load_byte);
    end

endmodule

// File: rtl/region_decode.sv
// region_decode: maps an address onto the top protected window and the
// boot page. Window size is (page/2) << (max_sel - sel), or 0 at max_sel.
// Assumes ADDR_W == PAGE_W - 1 + 2**SIZE_W - 1 so the largest step covers all.
module region_decode #(
    parameter int ADDR_W = 17,
    parameter int PAGE_W = 11,
    parameter int SIZE_W = 3
) (
    input  logic [SIZE_W-1:0] size_sel,
    input  logic              boot_open,
    input  logic [ADDR_W-1:0] addr,
    output logic              in_top,
    output logic              in_boot
);

    localparam logic [SIZE_W-1:0] SEL_MAX = {SIZE_W{1'b1}};
    localparam logic [ADDR_W:0]   FULL    = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [ADDR_W:0]   STEP    = {{ADDR_W{1'b0}}, 1'b1} << (PAGE_W - 1);

    logic [SIZE_W-1:0] step_cnt;
    logic [ADDR_W:0]   win_bytes;
    logic [ADDR_W:0]   win_base;

    // Compute the window base and compare the address against both regions.
    always_comb begin
        step_cnt  = SEL_MAX - size_sel;
        win_bytes = (step_cnt == '0) ? '0 : (STEP << step_cnt);
        win_base  = FULL - win_bytes;
        in_top    = ({1'b0, addr} >= win_base);
        in_boot   = !boot_open && (addr[ADDR_W-1:PAGE_W] == '0);
    end

endmodule

// File: rtl/flash_guard.sv
// flash_guard: qualifies flash write/erase requests against the stored lock
// byte and answers with a registered grant or deny one cycle later.
// Assumes at most one request per cycle and that requests issued on a
// load cycle are judged against the previous byte.
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int PAGE_W = 11,
    parameter int SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [7:0]        cfg_byte,
    input  logic              erase_done,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_info,
    input  logic              req_from_dbg,
    output logic              grant,
    output logic              deny,
    output logic              dbg_locked
);

    lock_t lock_q;
    logic  in_top, in_boot;
    logic  allow;
    req_kind_e kind;

    lock_store #(.RESET_VAL(8'h00), .WIPE_VAL(8'hFF)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cfg_load),
        .load_byte (cfg_byte),
        .wipe      (erase_done),
        .lock_q    (lock_q)
    );

    region_decode #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SIZE_W(SIZE_W)) u_region (
        .size_sel  (lock_q.size_sel),
        .boot_open (lock_q.boot_open),
        .addr      (req_addr),
        .in_top    (in_top),
        .in_boot   (in_boot)
    );

    // Decide whether the presented request may proceed.
    always_comb begin
        kind = req_kind_e'(req_kind);
        case (kind)
            KIND_CERASE: allow = 1'b1;
            KIND_RSVD:   allow = 1'b0;
            default:     allow = req_info ? req_from_dbg : !(in_top || in_boot);
        endcase
    end

    // Register the answer as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant <= 1'b0;
            deny  <= 1'b0;
        end else begin
            grant <= req_valid && allow;
            deny  <= req_valid && !allow;
        end
    end

    // Export the debug-disable state.
    always_comb dbg_locked = !lock_q.dbg_open;

    // R2: one answer per request, none otherwise
    p_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && deny));
    p_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (grant || deny));
    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!grant && !deny));
    // R5: boot page locked blocks low writes
    p_boot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_info && (req_kind == 2'd0) && !lock_q.boot_open
         && (req_addr < ADDR_W'(2**PAGE_W))) |=> deny);
    // R6: info page needs the debug link
    p_info_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_info && !req_kind[1]) |=> (grant == $past(req_from_dbg)));
    // R7: chip erase always passes
    p_chip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd2) |=> grant);
    // R8: erase completion releases debug lock
    p_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done |=> !dbg_locked);
    // R9: reserved kind refused
    p_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3) |=> deny);

endmodule

// File: tb/test_flash_guard.sv
module test_flash_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [7:0]  cfg_byte = 8'h00;
    logic        erase_done = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [16:0] req_addr = '0;
    logic        req_info = 1'b0;
    logic        req_from_dbg = 1'b0;
    logic        grant, deny, dbg_locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    flash_guard i_flash_guard (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_byte(cfg_byte),
        .erase_done(erase_done), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_info(req_info), .req_from_dbg(req_from_dbg),
        .grant(grant), .deny(deny), .dbg_locked(dbg_locked)
    );

    // vector: {req id, lock byte, kind, addr, info, from_dbg, expect grant}
    localparam int NV = 14;
    localparam logic [33:0] VEC [NV] = '{
        {4'd4, 8'hFF, 2'd0, 17'h1FFFF, 1'b0, 1'b0, 1'b1},  // R4 size 0 KB
        {4'd4, 8'hF1, 2'd0, 17'h00000, 1'b0, 1'b0, 1'b0},  // R4 128 KB
        {4'd4, 8'hFD, 2'd0, 17'h1F800, 1'b0, 1'b0, 1'b0},  // R4 2 KB edge
        {4'd4, 8'hFD, 2'd0, 17'h1F7FF, 1'b0, 1'b0, 1'b1},  // R4 below edge
        {4'd4, 8'hF9, 2'd1, 17'h1E000, 1'b0, 1'b0, 1'b0},  // R4 8 KB edge
        {4'd4, 8'hF9, 2'd0, 17'h1DFFF, 1'b0, 1'b0, 1'b1},  // R4 below edge
        {4'd5, 8'hEF, 2'd0, 17'h007FF, 1'b0, 1'b0, 1'b0},  // R5 boot top
        {4'd5, 8'hEF, 2'd0, 17'h00800, 1'b0, 1'b0, 1'b1},  // R5 above boot
        {4'd5, 8'hEF, 2'd1, 17'h00000, 1'b0, 1'b0, 1'b0},  // R5 page erase
        {4'd5, 8'hFF, 2'd1, 17'h00000, 1'b0, 1'b0, 1'b1},  // R5 unlocked
        {4'd7, 8'h00, 2'd2, 17'h00000, 1'b0, 1'b0, 1'b1},  // R7 chip erase
        {4'd6, 8'hFF, 2'd0, 17'h1FFFF, 1'b1, 1'b0, 1'b0},  // R6 non-debug
        {4'd6, 8'h00, 2'd0, 17'h1FFFF, 1'b1, 1'b1, 1'b1},  // R6 debug
        {4'd9, 8'hFF, 2'd3, 17'h00100, 1'b0, 1'b0, 1'b0}   // R9 reserved
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load_byte(input logic [7:0] b);
        @(negedge clk); cfg_load = 1'b1; cfg_byte = b;
        @(negedge clk); cfg_load = 1'b0;
    endtask

    // Present a request on one negedge; answer is read at the next negedge.
    task automatic request(input logic [1:0] k, input logic [16:0] a,
                           input logic inf, input logic dbg);
        req_valid = 1'b1; req_kind = k; req_addr = a;
        req_info = inf; req_from_dbg = dbg;
        @(negedge clk); req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dbg_locked == 1'b1, "R1 dbg_locked in reset", dbg_locked, 1);
        chk({grant, deny} == 2'b00, "R1 outputs idle in reset", {grant, deny}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dbg_locked == 1'b1, "R1 locked before load", dbg_locked, 1);

        for (int i = 0; i < NV; i++) begin
            load_byte(VEC[i][29:22]);
            request(VEC[i][21:20], VEC[i][19:3], VEC[i][2], VEC[i][1]);
            chk(grant == VEC[i][0] && deny == !VEC[i][0],
                $sformatf("R%0d vector %0d grant", VEC[i][33:30], i), grant, int'(VEC[i][0]));
        end
        // R2: answer lasts one cycle only
        @(negedge clk);
        chk({grant, deny} == 2'b00, "R2 no answer without request", {grant, deny}, 0);

        // R3: debug lock bit
        load_byte(8'hFE);
        chk(dbg_locked == 1'b1, "R3 bit0=0 locks debug", dbg_locked, 1);
        load_byte(8'hFF);
        chk(dbg_locked == 1'b0, "R3 bit0=1 opens debug", dbg_locked, 0);

        // R10: request on the load cycle uses the old (fully protected) byte
        load_byte(8'hF1);
        cfg_load = 1'b1; cfg_byte = 8'hFF;
        request(2'd0, 17'h00010, 1'b0, 1'b0);
        cfg_load = 1'b0;
        chk(deny == 1'b1, "R10 same-cycle load uses old byte", deny, 1);
        request(2'd0, 17'h00010, 1'b0, 1'b0);
        chk(grant == 1'b1, "R10 next request uses new byte", grant, 1);

        // R8: chip erase completion reloads all ones, winning over a load
        load_byte(8'h00);
        request(2'd2, 17'h0, 1'b0, 1'b0);
        chk(grant == 1'b1, "R7 chip erase while locked", grant, 1);
        erase_done = 1'b1; cfg_load = 1'b1; cfg_byte = 8'h00;
        @(negedge clk); erase_done = 1'b0; cfg_load = 1'b0;
        chk(dbg_locked == 1'b0, "R8 debug released after erase", dbg_locked, 0);
        request(2'd0, 17'h1FFFF, 1'b0, 1'b0);
        chk(grant == 1'b1, "R8 top write granted after erase", grant, 1);
        request(2'd0, 17'h00000, 1'b0, 1'b0);
        chk(grant == 1'b1, "R8 boot write granted after erase", grant, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule